// File: doc/BRIEF.md
# Two-Bank Graphics DRAM Command Decoder and Legality Monitor

This block watches the command pins of a two-bank synchronous graphics DRAM interface. On every rising clock edge it turns the sampled pins into a single command code and reports which bank the command addresses. The pins are chip select, the three low-active row, column and write strobes, clock enable, the special-function pin, the byte masks and the address. The block also keeps a model of the device state that the legality rules need: which banks are open, which banks were opened in masked-write mode, the programmed burst length, bursts with automatic precharge that are still running, and whether the data bus still carries a burst.

Each command that breaks a state rule raises a one-cycle error pulse and leaves the state unchanged. Examples are activating an open bank, reading a closed bank, or programming the mode while a row is open. The block also reports the byte masks that apply to write data, and it produces the read output-disable mask, which lags the mask pins by the read latency.

A controller or a bus monitor places the block next to the memory pins. The memory array, the data path and the analog timing are outside its scope.

Top module: `sgram_cmd_monitor`

## Requirements
- R1: While reset is high and after it is released, `open_o`=0, `illegal_o`=0, `cmd_o`=0 (no-op), `wpb_o`=0, `wr_mask_o`=0 and `dq_hiz_o`=0.
- R2: Command codes on `cmd_o` are 0 no-op, 1 deselect, 2 mode set, 3 special mode set, 4 refresh, 6 activate, 7 read, 8 write, 9 block write, 10 burst stop and 11 precharge. They are decoded from {ras_n,cas_n,we_n}: 111 no-op, 000 mode set (dsf=1: special), 001 refresh, 011 activate, 101 read, 100 write (dsf=1: block write), 110 burst stop, 010 precharge. cs_n=1 gives deselect. When the cke sampled on the previous edge was 0, the cycle is code 13 (suspended) and has no effect.
- R3: When cke was 1 on the previous edge and is 0 now, refresh becomes code 5 (self refresh), and no-op or deselect becomes code 12 (power down).
- R4: For activate, read, write, block write and precharge, `bank_o` equals address bit 10 (0 = bank A, which is `open_o[0]`; 1 = bank B).
- R5: A legal precharge with address bit 9 = 1 closes both banks whatever bit 10 is. With bit 9 = 0 it closes only the selected bank.
- R6: Mode set, refresh and self refresh are illegal while any bank is open. A legal mode set stores address bits 2:0 as the burst-length code (0:1, 1:2, 2:4, 3:8, 7:full page of PAGE_LEN beats, other codes: 1). After reset the code is 0.
- R7: A special mode set is illegal while burst beats remain on the data bus.
- R8: Activating an open bank, or a read, write or block write to a closed bank, raises `illegal_o` for one cycle. No illegal command changes any state.
- R9: A legal read or write with address bit 9 = 1 starts an auto-precharge burst of the burst length (block write: one beat). The bank closes that many enabled edges later, and column commands to it before then are illegal.
- R10: Burst stop is illegal unless the burst-length code is 7. A legal burst stop ends the data-bus burst.
- R11: Activate latches dsf as the bank's masked-write setting. A legal write or block write reports that setting on `wpb_o`.
- R12: `wr_mask_o` shows the dqm of a write or block-write cycle, together with its command code. `dq_hiz_o` shows the dqm sampled two rising edges earlier.
- R13: With dsf held low, no graphics command appears: the 100 pattern decodes as write, the 000 pattern as mode set, and `wpb_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write strobe, low active |
| cke | input | 1 | Clock enable |
| dsf | input | 1 | Special-function select |
| dqm | input | DQM_W | Byte masks |
| addr | input | ADDR_W | Address; bit 10 bank, bit 9 all/auto-precharge |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 1 | Addressed bank |
| illegal_o | output | 1 | One-cycle rule-violation pulse |
| open_o | output | 2 | Open state per bank |
| wpb_o | output | 1 | Masked-write mode for this write |
| wr_mask_o | output | DQM_W | Byte mask of this write |
| dq_hiz_o | output | DQM_W | Read output-disable mask |

## Verification
The command code, bank, error pulse, masked-write flag and write mask all come out of one register stage. The bench drives each pin set at a falling edge and compares these outputs at the next falling edge, one rising edge later. `open_o` updates at that same edge, so the closing of an auto-precharge bank is seen exactly the burst length of enabled edges after the column command. `dq_hiz_o` is compared against the mask that was driven one step before the current one, which gives the two-edge read latency. A bench reference model applies the rules in the order of the requirements and supplies the expected values every cycle.

// File: rtl/sgram_mon_pkg.sv
package sgram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_DESEL = 4'd1,
    CMD_MRS   = 4'd2,
    CMD_SMRS  = 4'd3,
    CMD_REF   = 4'd4,
    CMD_SREF  = 4'd5,
    CMD_ACT   = 4'd6,
    CMD_RD    = 4'd7,
    CMD_WR    = 4'd8,
    CMD_BWR   = 4'd9,
    CMD_BST   = 4'd10,
    CMD_PRE   = 4'd11,
    CMD_PDOWN = 4'd12,
    CMD_SUSP  = 4'd13
  } cmd_e;

  localparam logic [2:0] BL_CODE_FULL = 3'd7;

endpackage

// File: rtl/sgram_cmd_decode.sv
module sgram_cmd_decode
  import sgram_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  input  logic cke_q,
  input  logic dsf,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_NOP;
    if (!cke_q) begin
      cmd = CMD_SUSP;
    end else if (cs_n) begin
      cmd = cke ? CMD_DESEL : CMD_PDOWN;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111: cmd = cke ? CMD_NOP : CMD_PDOWN;
        3'b000: cmd = dsf ? CMD_SMRS : CMD_MRS;
        3'b001: cmd = cke ? CMD_REF : CMD_SREF;
        3'b011: cmd = CMD_ACT;
        3'b101: cmd = CMD_RD;
        3'b100: cmd = dsf ? CMD_BWR : CMD_WR;
        3'b110: cmd = CMD_BST;
        default: cmd = CMD_PRE;
      endcase
    end
  end

endmodule

// File: rtl/sgram_bank_slot.sv
module sgram_bank_slot #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             open_set,
  input  logic             wpb_val,
  input  logic             close,
  input  logic             ap_load,
  input  logic [CNT_W-1:0] ap_len,
  output logic             is_open,
  output logic             wpb,
  output logic             ap_busy
);

  logic [CNT_W-1:0] ap_cnt;

  assign ap_busy = (ap_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open <= 1'b0;
      wpb     <= 1'b0;
      ap_cnt  <= '0;
    end else begin
      if (tick && ap_busy) begin
        ap_cnt <= ap_cnt - 1'b1;
        if (ap_cnt == CNT_W'(1)) is_open <= 1'b0;
      end
      if (open_set) begin
        is_open <= 1'b1;
        wpb     <= wpb_val;
      end
      if (close) begin
        is_open <= 1'b0;
        ap_cnt  <= '0;
      end
      if (ap_load) ap_cnt <= ap_len;
    end
  end

endmodule

// File: rtl/sgram_dqm_pipe.sv
module sgram_dqm_pipe #(
  parameter int W   = 4,
  parameter int LAT = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage [LAT];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= din;
  end

  for (genvar s = 1; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s] <= '0;
      else     stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[LAT-1];

endmodule

// File: rtl/sgram_cmd_monitor.sv
module sgram_cmd_monitor
  import sgram_mon_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DQM_W    = 4,
  parameter int BANK_BIT = 10,
  parameter int AP_BIT   = 9,
  parameter int PAGE_LEN = 256,
  parameter int RD_LAT   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              cke,
  input  logic              dsf,
  input  logic [DQM_W-1:0]  dqm,
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        cmd_o,
  output logic              bank_o,
  output logic              illegal_o,
  output logic [1:0]        open_o,
  output logic              wpb_o,
  output logic [DQM_W-1:0]  wr_mask_o,
  output logic [DQM_W-1:0]  dq_hiz_o
);

  localparam int NBANK = 2;
  localparam int CNT_W = $clog2(PAGE_LEN + 1);

  logic             cke_q;
  cmd_e             dcmd;
  logic             dbank, dall;
  logic [2:0]       bl_code;
  logic [CNT_W-1:0] bus_cnt, blen, col_len;
  logic [NBANK-1:0] b_open, b_wpb, b_ap;
  logic             full_page, is_col, is_wr, bad, legal;
  logic             unused_addr;

  assign unused_addr = ^addr;
  assign dbank       = addr[BANK_BIT];
  assign dall        = addr[AP_BIT];

  sgram_cmd_decode u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cke  (cke),
    .cke_q(cke_q),
    .dsf  (dsf),
    .cmd  (dcmd)
  );

  assign full_page = (bl_code == BL_CODE_FULL);

  always_comb begin
    case (bl_code)
      3'd1:    blen = CNT_W'(2);
      3'd2:    blen = CNT_W'(4);
      3'd3:    blen = CNT_W'(8);
      3'd7:    blen = CNT_W'(PAGE_LEN);
      default: blen = CNT_W'(1);
    endcase
  end

  assign is_wr   = (dcmd == CMD_WR) || (dcmd == CMD_BWR);
  assign is_col  = is_wr || (dcmd == CMD_RD);
  assign col_len = (dcmd == CMD_BWR) ? CNT_W'(1) : blen;

  // rule table: any violation blocks every state update
  always_comb begin
    bad = 1'b0;
    case (dcmd)
      CMD_MRS, CMD_REF, CMD_SREF: bad = |b_open;
      CMD_SMRS:                   bad = (bus_cnt != '0);
      CMD_ACT:                    bad = b_open[dbank];
      CMD_RD, CMD_WR, CMD_BWR:    bad = !b_open[dbank] || b_ap[dbank];
      CMD_BST:                    bad = !full_page;
      default:                    bad = 1'b0;
    endcase
  end

  assign legal = !bad;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = (int'(dbank) == b);
    sgram_bank_slot #(.CNT_W(CNT_W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .tick    (cke_q),
      .open_set(legal && (dcmd == CMD_ACT) && hit),
      .wpb_val (dsf),
      .close   (legal && (dcmd == CMD_PRE) && (dall || hit)),
      .ap_load (legal && is_col && dall && hit),
      .ap_len  (col_len),
      .is_open (b_open[b]),
      .wpb     (b_wpb[b]),
      .ap_busy (b_ap[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q   <= 1'b1;
      bl_code <= 3'd0;
      bus_cnt <= '0;
    end else begin
      cke_q <= cke;
      if (legal && (dcmd == CMD_MRS)) bl_code <= addr[2:0];
      if (cke_q) begin
        if (legal && is_col)                   bus_cnt <= col_len;
        else if (legal && (dcmd == CMD_BST))   bus_cnt <= '0;
        else if (bus_cnt != '0)                bus_cnt <= bus_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o     <= CMD_NOP;
      bank_o    <= 1'b0;
      illegal_o <= 1'b0;
      wpb_o     <= 1'b0;
      wr_mask_o <= '0;
    end else begin
      cmd_o     <= dcmd;
      bank_o    <= dbank;
      illegal_o <= bad;
      wpb_o     <= legal && is_wr && b_wpb[dbank];
      wr_mask_o <= is_wr ? dqm : '0;
    end
  end

  assign open_o = b_open;

  sgram_dqm_pipe #(.W(DQM_W), .LAT(RD_LAT)) u_dqm (
    .clk (clk),
    .rst (rst),
    .din (dqm),
    .dout(dq_hiz_o)
  );

endmodule

// File: rtl/sgram_mon_chk.sv
module sgram_mon_chk #(
  parameter int ADDR_W = 11,
  parameter int DQM_W  = 4,
  parameter int AP_BIT = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              cke,
  input logic              cke_q,
  input logic [DQM_W-1:0]  dqm,
  input logic [ADDR_W-1:0] addr,
  input logic [3:0]        cmd_o,
  input logic              bank_o,
  input logic              illegal_o,
  input logic [1:0]        open_o,
  input logic [DQM_W-1:0]  dq_hiz_o,
  input logic              full_pg
);

  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst)              age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R2
  desel_decode_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_n && cke && cke_q) |=> (cmd_o == 4'd1));

  // R6
  mode_open_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && cmd_o == 4'd2 && $past(open_o) != 2'b00) |-> illegal_o);

  // R5
  pre_all_chk: assert property (@(posedge clk) disable iff (rst)
    (cke_q && !cs_n && !ras_n && cas_n && !we_n && addr[AP_BIT]) |=> (open_o == 2'b00));

  // R12
  rd_mask_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (dq_hiz_o == $past(dqm, 2)));

  // R10
  bst_len_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && cmd_o == 4'd10 && !$past(full_pg)) |-> illegal_o);

  // R8
  act_open_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 4'd6 && !illegal_o) |-> open_o[bank_o]);

endmodule

bind sgram_cmd_monitor sgram_mon_chk #(
  .ADDR_W(ADDR_W), .DQM_W(DQM_W), .AP_BIT(AP_BIT)
) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .cke(cke), .cke_q(cke_q), .dqm(dqm), .addr(addr),
  .cmd_o(cmd_o), .bank_o(bank_o), .illegal_o(illegal_o),
  .open_o(open_o), .dq_hiz_o(dq_hiz_o), .full_pg(full_page)
);

// File: tb/sim_sgram_cmd_monitor.sv
module sim_sgram_cmd_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int PAGE = 256;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1, dsf = 1'b0;
  logic [3:0]  dqm = '0;
  logic [10:0] addr = '0;
  logic [3:0]  cmd_o, wr_mask_o, dq_hiz_o;
  logic        bank_o, illegal_o, wpb_o;
  logic [1:0]  open_o;

  sgram_cmd_monitor u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .dsf(dsf), .dqm(dqm), .addr(addr), .cmd_o(cmd_o), .bank_o(bank_o),
    .illegal_o(illegal_o), .open_o(open_o), .wpb_o(wpb_o), .wr_mask_o(wr_mask_o),
    .dq_hiz_o(dq_hiz_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;

  // reference state
  int m_code = 0, m_bus = 0;
  int m_ap [2];
  bit m_open [2], m_wpb [2];
  bit m_ckeq = 1'b1;
  logic [3:0] d_prev = '0;

  // expected outputs for the coming edge
  bit have_exp = 1'b0;
  int e_cmd; bit e_bank, e_ill, e_wpb, e_dsf;
  logic [1:0] e_open; logic [3:0] e_mask, e_hiz;
  string e_itag;

  function automatic int beats(int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return PAGE;
      default: return 1;
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic string ctag(int c, bit ds);
    if (c == 5 || c == 12) return "R3";
    if (!ds && (c == 8 || c == 2)) return "R13";
    return "R2";
  endfunction

  task automatic compare();
    chk(ctag(e_cmd, e_dsf), "cmd", int'(cmd_o), e_cmd);
    if (e_cmd inside {6, 7, 8, 9, 11}) chk("R4", "bank", int'(bank_o), int'(e_bank));
    chk(e_itag, "illegal", int'(illegal_o), int'(e_ill));
    chk(e_cmd == 11 ? "R5" : (e_cmd == 6 ? "R8" : "R9"), "open", int'(open_o), int'(e_open));
    chk(e_dsf ? "R11" : "R13", "wpb", int'(wpb_o), int'(e_wpb));
    chk("R12", "wr_mask", int'(wr_mask_o), int'(e_mask));
    chk("R12", "dq_hiz", int'(dq_hiz_o), int'(e_hiz));
  endtask

  task automatic model(bit cs, bit r, bit c, bit w, bit ck, bit ds, logic [3:0] dq, logic [10:0] ad);
    int cmd; bit bk, all, bad, col;
    bk = ad[10]; all = ad[9];
    if (!m_ckeq) cmd = 13;
    else if (cs) cmd = ck ? 1 : 12;
    else case ({r, c, w})
      3'b111: cmd = ck ? 0 : 12;
      3'b000: cmd = ds ? 3 : 2;
      3'b001: cmd = ck ? 4 : 5;
      3'b011: cmd = 6;
      3'b101: cmd = 7;
      3'b100: cmd = ds ? 9 : 8;
      3'b110: cmd = 10;
      default: cmd = 11;
    endcase
    col = cmd inside {7, 8, 9};
    bad = 1'b0; e_itag = "R8";
    case (cmd)
      2, 4, 5: begin bad = m_open[0] || m_open[1]; e_itag = "R6"; end
      3:       begin bad = (m_bus != 0); e_itag = "R7"; end
      6:       bad = m_open[bk];
      7, 8, 9: begin bad = !m_open[bk] || (m_ap[bk] != 0); if (m_open[bk]) e_itag = "R9"; end
      10:      begin bad = (m_code != 7); e_itag = "R10"; end
      default: bad = 1'b0;
    endcase
    e_cmd = cmd; e_bank = bk; e_ill = bad; e_dsf = ds;
    e_wpb  = !bad && (cmd == 8 || cmd == 9) && m_wpb[bk];
    e_mask = (cmd == 8 || cmd == 9) ? dq : 4'h0;
    e_hiz  = d_prev; d_prev = dq;
    if (!bad && cmd == 2) m_code = int'(ad[2:0]);
    if (m_ckeq) begin
      for (int b = 0; b < 2; b++)
        if (m_ap[b] != 0) begin
          if (m_ap[b] == 1) m_open[b] = 1'b0;
          m_ap[b]--;
        end
      if (m_bus != 0) m_bus--;
      if (!bad) begin
        int len;
        len = (cmd == 9) ? 1 : beats(m_code);
        if (cmd == 6) begin m_open[bk] = 1'b1; m_wpb[bk] = ds; end
        if (col) begin m_bus = len; if (all) m_ap[bk] = len; end
        if (cmd == 10) m_bus = 0;
        if (cmd == 11)
          for (int b = 0; b < 2; b++)
            if (all || bk == b[0]) begin m_open[b] = 1'b0; m_ap[b] = 0; end
      end
    end
    e_open = {m_open[1], m_open[0]};
    m_ckeq = ck;
    have_exp = 1'b1;
  endtask

  task automatic step(bit cs, bit r, bit c, bit w, bit ck, bit ds, logic [3:0] dq, logic [10:0] ad);
    @(negedge clk);
    if (have_exp) compare();
    cs_n = cs; ras_n = r; cas_n = c; we_n = w; cke = ck; dsf = ds; dqm = dq; addr = ad;
    model(cs, r, c, w, ck, ds, dq, ad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_ap[0] = 0; m_ap[1] = 0;
    m_open[0] = 0; m_open[1] = 0; m_wpb[0] = 0; m_wpb[1] = 0;
    void'($urandom(32'h51D3));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "cmd", int'(cmd_o), 0);
    chk("R1", "open", int'(open_o), 0);
    chk("R1", "illegal", int'(illegal_o), 0);
    chk("R1", "wpb", int'(wpb_o), 0);
    chk("R1", "wr_mask", int'(wr_mask_o), 0);
    chk("R1", "dq_hiz", int'(dq_hiz_o), 0);
    rst = 1'b0;

    // directed corner cases
    step(0,0,0,0, 1,0, 4'h0, 11'h002);  // R13 mode set, burst 4
    step(0,0,1,1, 1,1, 4'h1, 11'h000);  // R11 activate A masked
    step(0,1,0,0, 1,0, 4'h5, 11'h000);  // R12 write A, mask 0101
    step(0,1,0,1, 1,0, 4'h2, 11'h400);  // R8 read closed B
    step(0,0,0,0, 1,0, 4'h0, 11'h003);  // R6 mode set with A open
    step(0,1,1,0, 1,0, 4'h0, 11'h000);  // R10 stop, not full page
    step(0,0,1,1, 1,0, 4'hF, 11'h400);  // activate B
    step(0,1,0,1, 1,0, 4'h0, 11'h600);  // R9 read B auto-precharge
    step(0,0,0,0, 1,1, 4'h3, 11'h000);  // R7 special set, bus busy
    step(0,1,0,1, 1,0, 4'h0, 11'h400);  // R9 read B during auto-precharge
    for (int i = 0; i < 5; i++) step(0,1,1,1, 1,0, 4'(i), 11'h000);
    step(0,0,1,0, 1,0, 4'h0, 11'h200);  // R5 precharge all
    step(0,1,1,1, 0,0, 4'h0, 11'h000);  // R3 power down
    step(0,1,1,1, 0,0, 4'h0, 11'h000);  // R2 suspended
    step(1,1,1,1, 1,0, 4'h0, 11'h000);
    step(0,0,0,1, 0,0, 4'h0, 11'h000);  // R3 self refresh
    step(1,1,1,1, 1,0, 4'h0, 11'h000);
    step(1,1,1,1, 1,0, 4'h0, 11'h000);
    step(0,0,0,0, 1,0, 4'h0, 11'h007);  // R6 full page
    step(0,0,1,1, 1,0, 4'h0, 11'h000);
    step(0,1,0,1, 1,0, 4'h0, 11'h000);
    step(0,1,1,0, 1,0, 4'h0, 11'h000);  // R10 legal stop
    step(0,0,0,0, 1,1, 4'h0, 11'h000);  // R7 special set, bus idle
    step(0,0,1,0, 1,0, 4'h0, 11'h200);

    // constrained random traffic
    for (int n = 0; n < 6000; n++) begin
      int k; logic [2:0] pat; logic [10:0] a; bit cs, ck;
      k = int'($urandom % 100);
      cs = ($urandom % 16 == 0);
      ck = ($urandom % 24 != 0);
      if      (k < 25) pat = 3'b111;
      else if (k < 40) pat = 3'b011;
      else if (k < 55) pat = 3'b101;
      else if (k < 68) pat = 3'b100;
      else if (k < 80) pat = 3'b010;
      else if (k < 87) pat = 3'b000;
      else if (k < 93) pat = 3'b110;
      else             pat = 3'b001;
      a = 11'($urandom);
      if (pat == 3'b000 && ($urandom % 2 == 0)) a[2:0] = 3'd7;
      if (pat inside {3'b101, 3'b100} && ($urandom % 3 != 0)) a[9] = 1'b0;
      step(cs, pat[2], pat[1], pat[0], ck, 1'($urandom), 4'($urandom), a);
    end
    step(1,1,1,1, 1,0, 4'h0, 11'h000);
    @(negedge clk);
    compare();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule